// File: doc/BRIEF.md
# ECC Error Event Router

This block sits between a memory controller's ECC error detectors and the chip's system error signalling. It watches two error flags, one for uncorrectable (multi-bit) errors and one for corrected (single-bit) errors. It turns each new error event into a single one-cycle request for a notification message. There are three message kinds: a system error (SERR), a system management interrupt (SMI) and a system control interrupt (SCI).

Software selects the message kind for each error class through three 16-bit command registers, one per message kind. Each register has an enable bit for each error class. SERR requests are also gated by a global SERR enable, which arrives as a separate input from the device command register.

A request is raised only on the rising edge of a flag. If software enables more than one kind for the same class, a fixed priority picks one. If both classes rise together, the two requests are sent in back-to-back cycles.

Top module: `ecc_err_router`

## Requirements
- R1: After reset, and again after any later reset, all three command registers read 0000h and no request is raised until software sets an enable.
- R2: The command registers are at byte offsets CAh (SERR), CCh (SMI) and CEh (SCI). In each register, bit 1 enables multi-bit errors and bit 0 enables single-bit errors. Bits 15:2 are read-only and read as zero. Any other offset reads 0000h, and a write to it changes no register.
- R3: A multi-bit or single-bit flag rising while the matching SERR bit is 1 and the global SERR enable is 1 gives one request with msg_type_o = 0 (SERR). msg_class_o is 1 for a multi-bit error and 0 for a single-bit error.
- R4: While the global SERR enable is 0, no SERR request is raised. The SERR bit is then treated as clear, and a lower-priority enabled kind is used instead.
- R5: A rising flag whose class is enabled only in the SMI register gives a request with msg_type_o = 1. If it is enabled only in the SCI register, the request has msg_type_o = 2.
- R6: When several kinds are enabled for a class, only the highest-priority kind is requested. SERR comes first, then SMI, then SCI.
- R7: A request is raised in the cycle after the clock edge that samples the flag's rise, and it lasts one cycle. A flag that stays high raises no further requests. A new rise after the flag falls raises a new request.
- R8: When both flags rise on the same edge and both classes are enabled, the multi-bit request comes first. The single-bit request follows in the next cycle.
- R9: A rising flag whose class has no enabled kind raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |
| serr_glb_en_i | input | 1 | Global SERR enable |
| mbe_flag_i | input | 1 | Multi-bit error flag |
| sbe_flag_i | input | 1 | Single-bit error flag |
| msg_valid_o | output | 1 | One-cycle message request |
| msg_type_o | output | 2 | 0 = SERR, 1 = SMI, 2 = SCI |
| msg_class_o | output | 1 | 1 = multi-bit, 0 = single-bit |

## Verification
The routing is exercised with each error class enabled in exactly one register, to confirm that each class reaches the correct kind and class code. It is then exercised with overlapping enables across registers, which separates the SERR > SMI > SCI priority from any other ordering. The global enable is toggled with and without a lower-priority fallback, which distinguishes suppression from rerouting. Simultaneous rises with different routes per class show both the ordering and that each queued request keeps its own route. Held flags and class/enable mismatches show that a request comes only from an enabled rise.

// File: rtl/ecc_rtr_pkg.sv
package ecc_rtr_pkg;
  localparam int unsigned NUM_MSG = 3;
  localparam int unsigned NUM_CLS = 2;
  localparam int unsigned CMD_W   = 16;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned TYPE_W  = $clog2(NUM_MSG);
  localparam int unsigned CLS_W   = $clog2(NUM_CLS);
  localparam int unsigned CMD_STRIDE = 2;
  localparam logic [ADDR_W-1:0] CMD_BASE = 8'hCA;

  typedef enum logic [TYPE_W-1:0] {
    MSG_SERR = 2'd0,
    MSG_SMI  = 2'd1,
    MSG_SCI  = 2'd2
  } msg_e;
endpackage

// File: rtl/ecc_rtr_regs.sv
module ecc_rtr_regs
  import ecc_rtr_pkg::*;
#(
  parameter int unsigned NMSG = NUM_MSG,
  parameter int unsigned NCLS = NUM_CLS,
  parameter int unsigned DW   = CMD_W,
  parameter int unsigned AW   = ADDR_W,
  parameter logic [AW-1:0] BASE = CMD_BASE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  output logic [NMSG-1:0][NCLS-1:0] en_o
);
  logic [NMSG-1:0]           hit;
  logic [NMSG-1:0][NCLS-1:0] cmd_q;

  for (genvar g = 0; g < NMSG; g++) begin : g_cmd
    localparam logic [AW-1:0] ADDR_G = BASE + AW'(CMD_STRIDE * g);
    assign hit[g] = (addr_i == ADDR_G);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmd_q[g] <= '0;
      else if (we_i && hit[g]) cmd_q[g] <= wdata_i[NCLS-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NMSG; i++)
      if (hit[i]) rdata_o[NCLS-1:0] = cmd_q[i];
  end

  assign en_o = cmd_q;

  // R2
  wr_serr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == BASE) |=> (cmd_q[0] == $past(wdata_i[NCLS-1:0])));
endmodule

// File: rtl/ecc_rtr_prio.sv
module ecc_rtr_prio #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  en_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ecc_rtr_arb.sv
module ecc_rtr_arb
  import ecc_rtr_pkg::*;
#(
  parameter int unsigned NCLS = NUM_CLS,
  parameter int unsigned CW   = CLS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLS-1:0] evt_i,
  input  logic [NCLS-1:0] arm_i,
  output logic            valid_o,
  output logic [CW-1:0]   cls_o
);
  logic [NCLS-1:0] prev_q, pend_q, rise, set, gnt;

  assign rise = evt_i & ~prev_q;
  assign set  = rise & arm_i;

  // highest class index (multi-bit) served first
  always_comb begin
    gnt   = '0;
    cls_o = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (pend_q[i]) begin
        gnt   = '0;
        gnt[i] = 1'b1;
        cls_o = CW'(i);
      end
    end
  end

  assign valid_o = |pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= evt_i;
      pend_q <= (pend_q & ~gnt) | set;
    end
  end

  // R7
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[1] && !set[1]) |=> !pend_q[1]);

  // R8
  mbe_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[1] && pend_q[0] && !set[1]) |=> (!pend_q[1] && pend_q[0]));
endmodule

// File: rtl/ecc_err_router.sv
module ecc_err_router
  import ecc_rtr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [CMD_W-1:0]    reg_wdata_i,
  output logic [CMD_W-1:0]    reg_rdata_o,
  input  logic                serr_glb_en_i,
  input  logic                mbe_flag_i,
  input  logic                sbe_flag_i,
  output logic                msg_valid_o,
  output logic [TYPE_W-1:0]   msg_type_o,
  output logic [CLS_W-1:0]    msg_class_o
);
  logic [NUM_MSG-1:0][NUM_CLS-1:0] en_w;
  logic [NUM_CLS-1:0]              route_v;
  logic [NUM_CLS-1:0][TYPE_W-1:0]  route_t;
  logic                            pend_v;
  logic [CLS_W-1:0]                pend_cls;

  ecc_rtr_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en_w)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [NUM_MSG-1:0] cls_en;
    for (genvar m = 0; m < NUM_MSG; m++) begin : g_msg
      if (m == int'(MSG_SERR)) begin : g_glb
        assign cls_en[m] = en_w[m][c] & serr_glb_en_i;
      end else begin : g_pl
        assign cls_en[m] = en_w[m][c];
      end
    end
    ecc_rtr_prio #(.N(NUM_MSG), .IW(TYPE_W)) u_prio (
      .en_i    (cls_en),
      .valid_o (route_v[c]),
      .idx_o   (route_t[c])
    );
  end

  ecc_rtr_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   ({mbe_flag_i, sbe_flag_i}),
    .arm_i   (route_v),
    .valid_o (pend_v),
    .cls_o   (pend_cls)
  );

  // route re-evaluated when served; a request whose route was cleared is dropped
  assign msg_valid_o = pend_v & route_v[pend_cls];
  assign msg_type_o  = route_t[pend_cls];
  assign msg_class_o = pend_cls;

  // R4
  serr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_SERR) |-> serr_glb_en_i);

  // R9
  enabled_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> en_w[msg_type_o][msg_class_o]);

  // R6
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_SCI) |-> !en_w[MSG_SMI][msg_class_o]);
endmodule

// File: tb/tb_ecc_err_router.sv
module tb_ecc_err_router;
  import ecc_rtr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        gen = 1'b0, mbe = 1'b0, sbe = 1'b0;
  logic        mv;
  logic [1:0]  mt;
  logic        mc;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecc_err_router dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .serr_glb_en_i(gen),
    .mbe_flag_i(mbe), .sbe_flag_i(sbe), .msg_valid_o(mv),
    .msg_type_o(mt), .msg_class_o(mc)
  );

  typedef struct packed {
    logic [1:0] serr, smi, sci;
    logic       gen, mbe, sbe;
    logic       v0; logic [1:0] t0; logic c0;
    logic       v1; logic [1:0] t1; logic c1;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 2'b00, 2'b00, 1, 1, 0, 1, 2'd0, 1, 0, 2'd0, 0, 8'd3}, // R3 mbe->SERR
    '{2'b01, 2'b00, 2'b00, 1, 0, 1, 1, 2'd0, 0, 0, 2'd0, 0, 8'd3}, // R3 sbe->SERR
    '{2'b10, 2'b00, 2'b00, 0, 1, 0, 0, 2'd0, 0, 0, 2'd0, 0, 8'd4}, // R4 suppressed
    '{2'b10, 2'b10, 2'b00, 0, 1, 0, 1, 2'd1, 1, 0, 2'd0, 0, 8'd4}, // R4 falls to SMI
    '{2'b00, 2'b01, 2'b00, 1, 0, 1, 1, 2'd1, 0, 0, 2'd0, 0, 8'd5}, // R5 SMI
    '{2'b00, 2'b00, 2'b10, 1, 1, 0, 1, 2'd2, 1, 0, 2'd0, 0, 8'd5}, // R5 SCI
    '{2'b11, 2'b11, 2'b11, 1, 1, 0, 1, 2'd0, 1, 0, 2'd0, 0, 8'd6}, // R6 SERR wins
    '{2'b00, 2'b10, 2'b10, 1, 1, 0, 1, 2'd1, 1, 0, 2'd0, 0, 8'd6}, // R6 SMI over SCI
    '{2'b01, 2'b00, 2'b10, 1, 1, 1, 1, 2'd2, 1, 1, 2'd0, 0, 8'd8}, // R8 both rise
    '{2'b00, 2'b00, 2'b00, 1, 1, 1, 0, 2'd0, 0, 0, 2'd0, 0, 8'd9}, // R9 none enabled
    '{2'b10, 2'b00, 2'b00, 1, 0, 1, 0, 2'd0, 0, 0, 2'd0, 0, 8'd9}  // R9 class mismatch
  };

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input int tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic msg_chk(input int tag, input logic v, input logic [1:0] t, input logic c);
    chk(tag, {31'd0, mv}, {31'd0, v});
    if (v) begin
      chk(tag, {30'd0, mt}, {30'd0, t});
      chk(tag, {31'd0, mc}, {31'd0, c});
    end
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int cnt;
    // R1 reset state
    #3;
    addr = 8'hCA; #1; chk(1, rdata, 16'h0);
    addr = 8'hCC; #1; chk(1, rdata, 16'h0);
    addr = 8'hCE; #1; chk(1, rdata, 16'h0);
    chk(1, {31'd0, mv}, 32'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 flags rise with nothing enabled after reset
    @(negedge clk); gen = 1'b1; mbe = 1'b1; sbe = 1'b1;
    @(negedge clk); chk(1, {31'd0, mv}, 32'd0);
    @(negedge clk); chk(1, {31'd0, mv}, 32'd0);
    mbe = 1'b0; sbe = 1'b0;

    // R2 register map and masks
    wr(8'hCA, 16'hFFFF); rd_chk(2, 8'hCA, 16'h0003);
    wr(8'hCC, 16'h5555); rd_chk(2, 8'hCC, 16'h0001);
    wr(8'hCE, 16'hAAAA); rd_chk(2, 8'hCE, 16'h0002);
    wr(8'hC8, 16'hFFFF); rd_chk(2, 8'hC8, 16'h0000);
    wr(8'hCB, 16'h0000); rd_chk(2, 8'hCB, 16'h0000);
    rd_chk(2, 8'hCA, 16'h0003);
    rd_chk(2, 8'hCC, 16'h0001);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(8'hCA, {14'd0, VEC[i].serr});
      wr(8'hCC, {14'd0, VEC[i].smi});
      wr(8'hCE, {14'd0, VEC[i].sci});
      @(negedge clk);
      gen = VEC[i].gen; mbe = VEC[i].mbe; sbe = VEC[i].sbe;
      @(negedge clk); msg_chk(VEC[i].tag, VEC[i].v0, VEC[i].t0, VEC[i].c0);
      @(negedge clk); msg_chk(VEC[i].tag, VEC[i].v1, VEC[i].t1, VEC[i].c1);
      @(negedge clk); msg_chk(7, 1'b0, 2'd0, 1'b0); // R7 held flags stay quiet
      mbe = 1'b0; sbe = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R7 held flag gives one request, re-rise gives another
    wr(8'hCA, 16'h0000); wr(8'hCC, 16'h0000); wr(8'hCE, 16'h0002);
    @(negedge clk); mbe = 1'b1;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (mv) cnt++; end
    chk(7, cnt, 1);
    mbe = 1'b0;
    @(negedge clk); @(negedge clk); mbe = 1'b1;
    @(negedge clk); msg_chk(7, 1'b1, 2'd2, 1'b1);
    @(negedge clk); msg_chk(7, 1'b0, 2'd0, 1'b0);
    mbe = 1'b0;

    // R8 single-bit rise while multi-bit rises again: multi-bit first
    wr(8'hCE, 16'h0003);
    @(negedge clk); sbe = 1'b1; mbe = 1'b1;
    @(negedge clk); msg_chk(8, 1'b1, 2'd2, 1'b1);
    @(negedge clk); msg_chk(8, 1'b1, 2'd2, 1'b0);
    @(negedge clk); msg_chk(8, 1'b0, 2'd0, 1'b0);
    sbe = 1'b0; mbe = 1'b0;

    // R1 registers cleared by a later reset
    wr(8'hCA, 16'h0003);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd_chk(1, 8'hCA, 16'h0000);
    rd_chk(1, 8'hCE, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end
endmodule